// File: doc/BRIEF.md
# Serial Program/Verify Command Interface (target side)

This block is the device-side front end of a two-wire serial programming port. A host drives a serial clock and a bidirectional data line. The host also holds a mode-entry level high for as long as the part sits in its high-voltage programming state. The block samples both wires with the on-chip clock and finds the clock edges itself. It assembles 6-bit commands, least significant bit first, and decodes them into one-cycle requests for the address counter and the memory sequencer.

Commands that carry a word are followed by a 16-cycle frame: a zero start bit, 14 data bits LSB first, and a zero stop bit. On a load frame the block collects the word and presents it once, on a valid strobe. On a read frame it takes a word from the memory side and drives it onto the data line. It turns the line around partway through the frame, so the host and the target never drive at the same time.

Neither output stream has back-pressure. The host clock cannot be stalled, so the memory side must accept each request and each loaded word in the cycle it is strobed. It must also hold the read word stable from the read request until the first rising clock edge of the frame. The memory side may raise a busy level while a self-timed erase or write runs. The block ignores serial clock edges for as long as busy is high.

Top module: `serprog_target`

## Requirements
- R1: The block serves the serial pins only if both the serial clock and the data line are low in the cycle the mode level rises. While the mode level is low, every internal state returns to idle within one cycle: sdat_oe=0, no strobes, and any partial command is discarded.
- R2: A command is six falling serial clock edges, with data sampled LSB first. One cycle after the sixth falling edge, req_valid pulses for exactly one cycle with req_op set to the decoded operation. The operations and their 6-bit codes (MSB..LSB) are: 1 load-config 000000, 2 load-program 000010, 3 load-data-memory 000011, 4 read-program 000100, 5 read-data-memory 000101, 6 increment 000110, 7 begin erase+write 001000, 8 begin write-only 011000, 9 bulk-erase program 001001, 10 bulk-erase data 001011.
- R3: Operations 1, 2 and 3 are followed by a 16-falling-edge frame. Falling edges 2 to 15 carry word bits 0 to 13. One cycle after the 16th falling edge, ld_valid pulses once with the word on ld_word.
- R4: For operation 3, ld_word bits 13:8 are zero and bits 7:0 hold the first eight data bits. The full 16 edges are still required before the next command starts.
- R5: Operations 4 and 5 are followed by a 16-cycle frame. rd_word_i is taken at the first rising edge. sdat_oe rises after the second rising edge, and after rising edge k (k=2..15) sdat_o carries bit k-2. After the 16th rising edge, sdat_oe=0 and sdat_o=0. sdat_o is 0 whenever sdat_oe is 0.
- R6: For operation 5, the bits driven for word positions 13:8 are zero.
- R7: Increment has no data phase, so the next falling edge starts the next command.
- R8: A begin operation (7 or 8) strobes only if a load frame has completed since entry or since the last accepted begin. Otherwise it produces no strobe. Accepting a begin clears that condition.
- R9: Serial clock edges that occur while busy_i is high are ignored entirely.
- R10: Any other 6-bit code produces no strobe and no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | High while the programming-entry level is held |
| sclk_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Data line as seen at the input buffer |
| busy_i | input | 1 | Erase or write in progress; serial edges are ignored |
| rd_word_i | input | WORD_W | Word at the current address, for read frames |
| sdat_o | output | 1 | Value driven onto the data line |
| sdat_oe | output | 1 | Data line output enable |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Operation code of the request (see R2) |
| ld_valid | output | 1 | One-cycle strobe for a completed load word |
| ld_word | output | WORD_W | Loaded word |

## Verification
The bench builds the block with its defaults, WORD_W=14 and DMEM_W=8. With these values the full 16-cycle frame is exercised, and so is the masking that clears six upper bits on data-memory loads and reads. A behavioural model runs beside the design and is compared every cycle. On top of it, directed sequences cover a bad entry, a mode drop in mid-command, an ignored begin, unknown codes and clock edges that arrive while busy.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int CMD_W = 6;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_LOAD_CFG  = 4'd1,
    OP_LOAD_PROG = 4'd2,
    OP_LOAD_DMEM = 4'd3,
    OP_READ_PROG = 4'd4,
    OP_READ_DMEM = 4'd5,
    OP_INCR      = 4'd6,
    OP_BEGIN_EW  = 4'd7,
    OP_BEGIN_W   = 4'd8,
    OP_BULK_PROG = 4'd9,
    OP_BULK_DMEM = 4'd10
  } op_e;

  typedef enum logic [1:0] {PH_CMD, PH_DIN, PH_DOUT} phase_e;

  typedef struct packed {
    op_e  op;
    logic known;
    logic has_in;
    logic has_out;
    logic is_begin;
    logic is_dmem;
  } dec_t;

  localparam logic [CMD_W-1:0] C_LOAD_CFG  = 6'b000000;
  localparam logic [CMD_W-1:0] C_LOAD_PROG = 6'b000010;
  localparam logic [CMD_W-1:0] C_LOAD_DMEM = 6'b000011;
  localparam logic [CMD_W-1:0] C_READ_PROG = 6'b000100;
  localparam logic [CMD_W-1:0] C_READ_DMEM = 6'b000101;
  localparam logic [CMD_W-1:0] C_INCR      = 6'b000110;
  localparam logic [CMD_W-1:0] C_BEGIN_EW  = 6'b001000;
  localparam logic [CMD_W-1:0] C_BEGIN_W   = 6'b011000;
  localparam logic [CMD_W-1:0] C_BULK_PROG = 6'b001001;
  localparam logic [CMD_W-1:0] C_BULK_DMEM = 6'b001011;
endpackage

// File: rtl/serprog_pinsync.sv
// Qualifies programming entry and turns the sampled serial clock into edge pulses.
module serprog_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic sclk_i,
  input  logic sdat_i,
  input  logic busy_i,
  output logic run,
  output logic rise,
  output logic fall
);
  logic mode_q, sclk_q, armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sclk_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      sclk_q <= sclk_i;
      if (!mode_i)
        armed_q <= 1'b0;
      else if (!mode_q)
        armed_q <= !sclk_i && !sdat_i;   // R1 entry qualification
    end
  end

  assign run  = armed_q && mode_i;
  assign rise = run && !busy_i && sclk_i && !sclk_q;
  assign fall = run && !busy_i && !sclk_i && sclk_q;
endmodule

// File: rtl/serprog_decode.sv
module serprog_decode
  import serprog_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output dec_t             dec
);
  always_comb begin
    dec.op       = OP_NONE;
    dec.known    = 1'b1;
    dec.has_in   = 1'b0;
    dec.has_out  = 1'b0;
    dec.is_begin = 1'b0;
    dec.is_dmem  = 1'b0;
    case (code)
      C_LOAD_CFG:  begin dec.op = OP_LOAD_CFG;  dec.has_in = 1'b1; end
      C_LOAD_PROG: begin dec.op = OP_LOAD_PROG; dec.has_in = 1'b1; end
      C_LOAD_DMEM: begin dec.op = OP_LOAD_DMEM; dec.has_in = 1'b1; dec.is_dmem = 1'b1; end
      C_READ_PROG: begin dec.op = OP_READ_PROG; dec.has_out = 1'b1; end
      C_READ_DMEM: begin dec.op = OP_READ_DMEM; dec.has_out = 1'b1; dec.is_dmem = 1'b1; end
      C_INCR:      dec.op = OP_INCR;
      C_BEGIN_EW:  begin dec.op = OP_BEGIN_EW; dec.is_begin = 1'b1; end
      C_BEGIN_W:   begin dec.op = OP_BEGIN_W;  dec.is_begin = 1'b1; end
      C_BULK_PROG: dec.op = OP_BULK_PROG;
      C_BULK_DMEM: dec.op = OP_BULK_DMEM;
      default:     dec.known = 1'b0;           // R10 no-operation
    endcase
  end
endmodule

// File: rtl/serprog_shift.sv
// Receive and transmit shift registers for the data frame, LSB first.
module serprog_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_en,
  input  logic         in_bit,
  input  logic         out_ld,
  input  logic [W-1:0] out_val,
  input  logic         out_sh,
  output logic [W-1:0] in_word,
  output logic         out_bit
);
  logic [W-1:0] in_sr, out_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sr  <= '0;
      out_sr <= '0;
    end else begin
      if (in_en)
        in_sr <= {in_bit, in_sr[W-1:1]};
      if (out_ld)
        out_sr <= out_val;
      else if (out_sh)
        out_sr <= {1'b0, out_sr[W-1:1]};
    end
  end

  assign in_word = in_sr;
  assign out_bit = out_sr[0];
endmodule

// File: rtl/serprog_target.sv
module serprog_target
  import serprog_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int DMEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              sdat_o,
  output logic              sdat_oe,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_word
);
  localparam int FRAME = WORD_W + 2;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FR_LAST  = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] W_LAST   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [WORD_W-1:0] DMASK   = {{(WORD_W-DMEM_W){1'b0}}, {DMEM_W{1'b1}}};

  logic run, rise, fall;
  phase_e phase;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-2:0] cmd_sr;
  logic dmem_q, loaded_q;
  logic mid;
  dec_t dec;
  logic in_en, out_ld, out_sh, out_bit;
  logic [WORD_W-1:0] in_word, out_val;

  serprog_pinsync u_pins (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sclk_i(sclk_i),
    .sdat_i(sdat_i), .busy_i(busy_i), .run(run), .rise(rise), .fall(fall)
  );

  serprog_decode u_dec (.code({sdat_i, cmd_sr}), .dec(dec));

  assign mid     = (cnt != '0) && (cnt <= W_LAST);
  assign in_en   = fall && (phase == PH_DIN) && mid;
  assign out_ld  = rise && (phase == PH_DOUT) && (cnt == '0);
  assign out_sh  = rise && (phase == PH_DOUT) && mid;
  assign out_val = dmem_q ? (rd_word_i & DMASK) : rd_word_i;

  serprog_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_bit(sdat_i),
    .out_ld(out_ld), .out_val(out_val), .out_sh(out_sh),
    .in_word(in_word), .out_bit(out_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      cmd_sr    <= '0;
      dmem_q    <= 1'b0;
      loaded_q  <= 1'b0;
      sdat_o    <= 1'b0;
      sdat_oe   <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= 4'd0;
      ld_valid  <= 1'b0;
      ld_word   <= '0;
    end else begin
      req_valid <= 1'b0;
      ld_valid  <= 1'b0;
      case (phase)
        PH_CMD: if (fall) begin
          if (cnt == CMD_LAST) begin
            cnt    <= '0;
            cmd_sr <= '0;
            req_op <= dec.op;
            dmem_q <= dec.is_dmem;
            if (dec.known && (!dec.is_begin || loaded_q))
              req_valid <= 1'b1;
            if (dec.is_begin && loaded_q)
              loaded_q <= 1'b0;                 // R8 consume load
            if (dec.has_in)
              phase <= PH_DIN;
            else if (dec.has_out)
              phase <= PH_DOUT;
          end else begin
            cnt    <= cnt + CNT_ONE;
            cmd_sr <= {sdat_i, cmd_sr[CMD_W-2:1]};
          end
        end
        PH_DIN: if (fall) begin
          if (cnt == FR_LAST) begin
            cnt      <= '0;
            phase    <= PH_CMD;
            ld_valid <= 1'b1;
            ld_word  <= dmem_q ? (in_word & DMASK) : in_word;
            loaded_q <= 1'b1;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        PH_DOUT: begin
          if (rise) begin
            if (mid) begin
              sdat_oe <= 1'b1;
              sdat_o  <= out_bit;
            end else if (cnt == FR_LAST) begin
              sdat_oe <= 1'b0;
              sdat_o  <= 1'b0;
            end
          end
          if (fall) begin
            if (cnt == FR_LAST) begin
              cnt   <= '0;
              phase <= PH_CMD;
            end else begin
              cnt <= cnt + CNT_ONE;
            end
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/serprog_target_chk.sv
module serprog_target_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic sclk_i,
  input logic busy_i,
  input logic sdat_oe,
  input logic req_valid,
  input logic ld_valid
);
  assert_mode_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> (!sdat_oe && !req_valid && !ld_valid));

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_ld_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);

  assert_oe_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> ($past(sclk_i) && !$past(busy_i)));

  assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && mode_i) |=> ($stable(sdat_oe) && !req_valid && !ld_valid));
endmodule

bind serprog_target serprog_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sclk_i(sclk_i), .busy_i(busy_i),
  .sdat_oe(sdat_oe), .req_valid(req_valid), .ld_valid(ld_valid)
);

// File: tb/serprog_target_tb.sv
module serprog_target_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0, busy_i = 1'b0;
  logic [13:0] rd_word = 14'd0;
  logic sdat_o, sdat_oe, req_valid, ld_valid;
  logic [3:0] req_op;
  logic [13:0] ld_word;

  always #10 clk = ~clk;

  serprog_target u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .busy_i(busy_i), .rd_word_i(rd_word), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
    .req_valid(req_valid), .req_op(req_op), .ld_valid(ld_valid), .ld_word(ld_word)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_ph, m_n, m_cmd, m_w, m_ow;
  bit m_armed, m_pmode, m_psclk, m_dm, m_loaded, m_run, m_r, m_f;
  bit e_rv, e_lv, e_oe, e_do;
  int e_op, e_lw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_n = 0; m_cmd = 0; m_w = 0; m_ow = 0;
      m_armed = 0; m_pmode = 0; m_psclk = 0; m_dm = 0; m_loaded = 0;
      e_rv = 0; e_lv = 0; e_oe = 0; e_do = 0; e_op = 0; e_lw = 0;
    end else begin
      m_run = m_armed && mode_i;
      m_r = m_run && !busy_i && sclk_i && !m_psclk;
      m_f = m_run && !busy_i && !sclk_i && m_psclk;
      e_rv = 0; e_lv = 0;
      if (!m_run) begin
        m_ph = 0; m_n = 0; m_cmd = 0; m_dm = 0; m_loaded = 0; e_oe = 0; e_do = 0;
      end else if (m_ph == 0 && m_f) begin
        m_cmd = m_cmd | (int'(sdat_i) << m_n);
        m_n++;
        if (m_n == 6) begin
          m_dm = 0;
          case (m_cmd)
            0:  begin e_rv = 1; e_op = 1; m_ph = 1; end
            2:  begin e_rv = 1; e_op = 2; m_ph = 1; end
            3:  begin e_rv = 1; e_op = 3; m_ph = 1; m_dm = 1; end
            4:  begin e_rv = 1; e_op = 4; m_ph = 2; end
            5:  begin e_rv = 1; e_op = 5; m_ph = 2; m_dm = 1; end
            6:  begin e_rv = 1; e_op = 6; end
            8:  if (m_loaded) begin e_rv = 1; e_op = 7; m_loaded = 0; end
            24: if (m_loaded) begin e_rv = 1; e_op = 8; m_loaded = 0; end
            9:  begin e_rv = 1; e_op = 9; end
            11: begin e_rv = 1; e_op = 10; end
            default: ;
          endcase
          m_n = 0; m_cmd = 0; m_w = 0;
        end
      end else if (m_ph == 1 && m_f) begin
        if (m_n >= 1 && m_n <= 14) m_w = m_w | (int'(sdat_i) << (m_n - 1));
        m_n++;
        if (m_n == 16) begin
          e_lv = 1; e_lw = m_dm ? (m_w & 'hFF) : m_w;
          m_loaded = 1; m_ph = 0; m_n = 0;
        end
      end else if (m_ph == 2) begin
        if (m_r) begin
          if (m_n == 0) m_ow = m_dm ? (int'(rd_word) & 'hFF) : int'(rd_word);
          else if (m_n <= 14) begin e_oe = 1; e_do = ((m_ow >> (m_n - 1)) & 1) != 0; end
          else begin e_oe = 0; e_do = 0; end
        end
        if (m_f) begin
          m_n++;
          if (m_n == 16) begin m_ph = 0; m_n = 0; end
        end
      end
      if (!mode_i) m_armed = 0;
      else if (!m_pmode) m_armed = !sclk_i && !sdat_i;
      m_pmode = mode_i; m_psclk = sclk_i;
    end
  end

  // Per-cycle comparison and strobe monitor
  int n_req = 0, n_ld = 0, last_op = 0, last_ld = 0;
  always @(negedge clk) if (rst_n) begin
    chk(req_valid == e_rv, "R2 req_valid", int'(req_valid), int'(e_rv));
    if (e_rv) chk(int'(req_op) == e_op, "R2 req_op", int'(req_op), e_op);
    chk(ld_valid == e_lv, "R3 ld_valid", int'(ld_valid), int'(e_lv));
    if (e_lv) chk(int'(ld_word) == e_lw, "R3 ld_word", int'(ld_word), e_lw);
    chk(sdat_oe == e_oe, "R5 sdat_oe", int'(sdat_oe), int'(e_oe));
    chk(sdat_o == e_do, "R5 sdat_o", int'(sdat_o), int'(e_do));
    if (req_valid) begin n_req++; last_op = int'(req_op); end
    if (ld_valid) begin n_ld++; last_ld = int'(ld_word); end
  end

  task automatic bitcyc(input bit b);
    @(negedge clk); sclk_i = 1'b1; sdat_i = b;
    repeat (4) @(negedge clk);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input int code);
    for (int i = 0; i < 6; i++) bitcyc(((code >> i) & 1) != 0);
    sdat_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input int w);
    bitcyc(1'b0);
    for (int i = 0; i < 14; i++) bitcyc(((w >> i) & 1) != 0);
    bitcyc(1'b0);
    sdat_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_frame(output int got);
    got = 0;
    sdat_i = 1'b0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); sclk_i = 1'b1;
      repeat (2) @(negedge clk);
      if (c >= 1 && c <= 14 && sdat_oe && sdat_o) got = got | (1 << (c - 1));
      repeat (2) @(negedge clk);
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic enter(input bit dat_level);
    @(negedge clk); mode_i = 1'b0; sclk_i = 1'b0; sdat_i = dat_level;
    repeat (3) @(negedge clk);
    mode_i = 1'b1;
    repeat (3) @(negedge clk);
    sdat_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    int r0, l0, got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sdat_oe && !req_valid && !ld_valid, "R1 reset idle", int'(sdat_oe), 0);

    // R1: bad entry, data high at mode rise
    enter(1'b1);
    r0 = n_req; l0 = n_ld;
    send_cmd(2); send_word('h1234);
    chk(n_req == r0 && n_ld == l0, "R1 bad entry ignored", n_req - r0 + n_ld - l0, 0);

    // R3: load program word
    enter(1'b0);
    send_cmd(2); send_word('h2A5C);
    chk(last_ld == 'h2A5C, "R3 load word", last_ld, 'h2A5C);

    // R8: begin after load strobes, repeat without load does not
    r0 = n_req;
    send_cmd(8);
    chk(n_req == r0 + 1 && last_op == 7, "R8 begin accepted", last_op, 7);
    r0 = n_req;
    send_cmd(24);
    chk(n_req == r0, "R8 begin without load", n_req - r0, 0);

    // R4: data-memory load keeps low byte
    send_cmd(3); send_word('h3FA5);
    chk(last_ld == 'h00A5, "R4 dmem load", last_ld, 'h00A5);
    r0 = n_req;
    send_cmd(24);
    chk(n_req == r0 + 1 && last_op == 8, "R8 write-only begin", last_op, 8);

    // R5: program read
    rd_word = 14'h1B3C;
    send_cmd(4); read_frame(got);
    chk(got == 'h1B3C, "R5 read word", got, 'h1B3C);
    chk(!sdat_oe, "R5 released", int'(sdat_oe), 0);

    // R6: data-memory read
    rd_word = 14'h3FC7;
    send_cmd(5); read_frame(got);
    chk(got == 'h00C7, "R6 dmem read", got, 'h00C7);

    // R7: increment then immediately load-config
    r0 = n_req;
    send_cmd(6); send_cmd(0);
    chk(n_req == r0 + 2 && last_op == 1, "R7 incr then next cmd", n_req - r0, 2);
    send_word('h3FFF);
    chk(last_ld == 'h3FFF, "R3 config word", last_ld, 'h3FFF);

    // R10: unknown codes, then increment decodes directly
    r0 = n_req;
    send_cmd('h3F); send_cmd('h07);
    chk(n_req == r0, "R10 unknown no strobe", n_req - r0, 0);
    send_cmd(6);
    chk(n_req == r0 + 1 && last_op == 6, "R10 no data phase", last_op, 6);

    // R9: edges while busy are ignored
    r0 = n_req;
    busy_i = 1'b1;
    send_cmd(6);
    busy_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(n_req == r0, "R9 busy ignores edges", n_req - r0, 0);
    send_cmd(9);
    chk(n_req == r0 + 1 && last_op == 9, "R9 after busy", last_op, 9);

    // R2: bulk erase data
    send_cmd(11);
    chk(last_op == 10, "R2 bulk data op", last_op, 10);

    // R1: mode drop mid-command discards partial bits
    bitcyc(1'b1); bitcyc(1'b1); bitcyc(1'b0);
    @(negedge clk); mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sdat_oe && !req_valid, "R1 mode low idle", int'(sdat_oe), 0);
    enter(1'b0);
    r0 = n_req;
    send_cmd(6);
    chk(n_req == r0 + 1 && last_op == 6, "R1 fresh after re-entry", last_op, 6);

    // R8: re-entry clears load condition
    send_cmd(2); send_word('h0001);
    enter(1'b0);
    r0 = n_req;
    send_cmd(8);
    chk(n_req == r0, "R8 cleared by re-entry", n_req - r0, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule